// File: doc/BRIEF.md
# Programmable Four-Way Chip-Select Decoder

This block turns a 32-bit bus address into four active-low chip selects. All four selects share one 4-bit base nibble. When address bits 31..28 match that nibble, address bits 27..26 pick one of four 64 MB windows.

Each select has its own configuration byte, written and read through a small register port. The byte holds an enable, a port-width bit and a wait-mode bit. The byte for select 0 also holds the shared base nibble and a boot flag. With each select the block reports the port width of the addressed device. It also raises an internal zero-wait acknowledge when the selected device is set for that mode.

After reset the block is in a boot mode. In this mode select 0 answers every strobed bus cycle whatever the address, so a processor can fetch from its boot device before any register is set up. The first write to the select 0 byte ends boot mode and starts normal decoding.

Top module: `cs_quad_decoder`

## Requirements
- R1: After reset all chip selects are high and `port_32` and `ack_int` are 0. Index 0 reads 0x40 (only the boot flag set), and indexes 1 to 3 read 0x00.
- R2: A write to index 0 stores bit 7 (enable), bit 5 (width), bit 4 (wait mode) and bits 3..0 (base nibble). Bit 6 of that index reads as the boot flag, not as the written value. Indexes 1 to 3 keep only bits 7, 5 and 4 and read 0 in all other bits. Writes to indexes 4 to 15 change nothing, and those indexes read 0x00.
- R3: While the boot flag is set, every clock edge that samples the strobe high makes `cs_n` equal 4'b1110 in the next cycle, for any address and any enable value. Width and acknowledge then follow the select 0 byte.
- R4: Any write to index 0 clears the boot flag, even when data bit 6 is 1. Writes to indexes 1 to 15 leave the flag set. Only reset sets it again.
- R5: Outside boot mode, suppose the strobe is high, address bits 31..28 equal the base nibble, and the select chosen by address bits 27..26 is enabled. Then that select's `cs_n` bit is low in the cycle after the edge that sampled those inputs.
- R6: A select whose enable bit is 0 stays high. No select asserts when address bits 31..28 differ from the base nibble.
- R7: `port_32` is the width bit (1 = 32-bit port, 0 = 16-bit port) of the asserted select, and it is 0 when no select is asserted.
- R8: `ack_int` is 1 together with an asserted select whose wait-mode bit is 0. It is 0 when that bit is 1 (external acknowledge) or when no select is asserted.
- R9: A clock edge that samples the strobe low drives all chip selects high, with `port_32` and `ack_int` at 0, in the following cycle.
- R10: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational readback of the indexed byte |
| bus_addr | input | 32 | Bus address |
| bus_strobe | input | 1 | Address strobe, active high |
| cs_n | output | 4 | Chip selects, active low, registered |
| port_32 | output | 1 | 1 when the selected port is 32 bits wide |
| ack_int | output | 1 | Internal zero-wait acknowledge |

## Verification
The bench attacks boot mode from several sides. It checks that select 0 answers odd addresses even while disabled, and that a write to another index does not end boot mode. It also checks that a write to index 0 with data bit 6 set still ends it; a design that copied bit 6 into the flag would stay stuck answering every cycle. Each window is tested with both width values and both wait modes, so a design that used the wrong select's bits for `port_32` or `ack_int`, or swapped the address bits that pick a select, shows a wrong output. The bench also covers base nibbles 0 and 15, a base mismatch, disabled selects, out-of-range indexes and the strobe falling after a hit. A design that latched a stale select would keep it low after the strobe drops.

// File: rtl/cs_quad_decoder.sv
module cs_quad_decoder #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  output logic [3:0]        cs_n,
  output logic              port_32,
  output logic              ack_int
);
  localparam int BASE_LSB = ADDR_W - 4;
  localparam int SEL_LSB  = ADDR_W - 6;

  logic [3:0] en_q, wid_q, wt_q, base_q;
  logic       boot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      wid_q  <= '0;
      wt_q   <= '0;
      base_q <= '0;
      boot_q <= 1'b1;
    end else if (cfg_we && cfg_idx < IDX_W'(4)) begin
      en_q[cfg_idx[1:0]]  <= cfg_wdata[7];
      wid_q[cfg_idx[1:0]] <= cfg_wdata[5];
      wt_q[cfg_idx[1:0]]  <= cfg_wdata[4];
      if (cfg_idx == '0) begin
        base_q <= cfg_wdata[3:0];
        boot_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (cfg_idx < IDX_W'(4))
      cfg_rdata = {en_q[cfg_idx[1:0]], 1'b0, wid_q[cfg_idx[1:0]], wt_q[cfg_idx[1:0]], 4'h0};
    if (cfg_idx == '0)
      cfg_rdata[6:0] = {boot_q, cfg_rdata[5:4], base_q};
  end

  logic [1:0] sel_w;
  logic       hit_w, any_w;
  logic [1:0] pick_w;

  assign sel_w  = bus_addr[SEL_LSB +: 2];
  assign hit_w  = (bus_addr[BASE_LSB +: 4] == base_q) && en_q[sel_w];
  assign any_w  = bus_strobe && (boot_q || hit_w);
  assign pick_w = boot_q ? 2'd0 : sel_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= 4'hF;
      port_32 <= 1'b0;
      ack_int <= 1'b0;
    end else begin
      cs_n    <= any_w ? ~(4'b0001 << pick_w) : 4'hF;
      port_32 <= any_w && wid_q[pick_w];
      ack_int <= any_w && !wt_q[pick_w];
    end
  end

  a_r3_boot_cs0: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q && bus_strobe) |=> (cs_n == 4'b1110));
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == '0) |=> !boot_q);
  a_r5_decode_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && bus_strobe && hit_w) |=> !cs_n[$past(sel_w)]);
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> (cs_n == 4'hF && !port_32 && !ack_int));
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r8_ack_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ack_int |-> (cs_n != 4'hF));
  a_r7_width_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    port_32 |-> (cs_n != 4'hF));
endmodule

// File: tb/cs_quad_decoder_tb.sv
module cs_quad_decoder_tb;
  localparam int PERIOD = 10;
  localparam int NV = 9;
  // {cfg0, cfg1, cfg2, cfg3, addr, cs_n, port_32, ack_int}
  localparam logic [69:0] VEC [NV] = '{
    {8'h85, 8'h00, 8'h00, 8'h00, 32'h5000_0000, 4'b1110, 1'b0, 1'b1},
    {8'h85, 8'hA0, 8'h00, 8'h00, 32'h5400_0000, 4'b1101, 1'b1, 1'b1},
    {8'h85, 8'h00, 8'h90, 8'h00, 32'h5800_0000, 4'b1011, 1'b0, 1'b0},
    {8'h85, 8'h00, 8'h00, 8'hB0, 32'h5C00_1234, 4'b0111, 1'b1, 1'b0},
    {8'h85, 8'h00, 8'h00, 8'hB0, 32'h6C00_0000, 4'b1111, 1'b0, 1'b0},
    {8'h85, 8'h30, 8'h00, 8'h00, 32'h5400_0000, 4'b1111, 1'b0, 1'b0},
    {8'h05, 8'h00, 8'h00, 8'h00, 32'h5000_0000, 4'b1111, 1'b0, 1'b0},
    {8'hFF, 8'h00, 8'h00, 8'h00, 32'hF3FF_FFFF, 4'b1110, 1'b1, 1'b0},
    {8'h80, 8'h00, 8'hA0, 8'h00, 32'h0800_0000, 4'b1011, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0, bus_strobe = 0;
  logic [3:0] cfg_idx = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [31:0] bus_addr = 0;
  logic [3:0] cs_n;
  logic port_32, ack_int;
  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  cs_quad_decoder u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .bus_strobe(bus_strobe), .cs_n(cs_n), .port_32(port_32), .ack_int(ack_int));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input string req, input logic [3:0] idx, input logic [7:0] exp);
    cfg_idx = idx; #1;
    chk(req, {24'h0, cfg_rdata}, {24'h0, exp});
  endtask

  task automatic cyc(input logic [31:0] a, input logic s);
    @(negedge clk); bus_addr = a; bus_strobe = s;
    @(negedge clk);
  endtask

  task automatic outs(input string req, input logic [3:0] c, input logic p, input logic k);
    chk(req, {26'h0, cs_n, port_32, ack_int}, {26'h0, c, p, k});
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    #(PERIOD * 3); rst_n = 1;
    @(negedge clk);
    outs("R1 reset outputs", 4'hF, 0, 0);
    rd("R1 idx0 reset", 0, 8'h40);
    rd("R1 idx1 reset", 1, 8'h00);
    cyc(32'h1234_5678, 1);
    outs("R3 boot any address", 4'b1110, 0, 1);
    cyc(32'hFFFF_FFFF, 0);
    outs("R9 boot no strobe", 4'hF, 0, 0);
    wr(1, 8'hFF);
    rd("R2 idx1 masked", 1, 8'hB0);
    rd("R4 idx1 write keeps flag", 0, 8'h40);
    wr(5, 8'hFF);
    rd("R2 idx5 reads zero", 5, 8'h00);
    rd("R2 idx5 write ignored", 0, 8'h40);
    cyc(32'h9000_0000, 1);
    outs("R3 boot still active", 4'b1110, 0, 1);
    wr(0, 8'h40);
    rd("R4 flag cleared by bit6 write", 0, 8'h00);
    cyc(32'h0000_0000, 1);
    outs("R6 disabled after boot", 4'hF, 0, 0);
    wr(0, 8'hA7);
    rd("R2 idx0 full byte", 0, 8'hA7);
    cyc(32'h7000_0000, 1);
    outs("R5 hit cs0", 4'b1110, 1, 1);
    cyc(32'h7000_0000, 0);
    outs("R9 strobe drop", 4'hF, 0, 0);
    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][69:62]); wr(1, VEC[i][61:54]);
      wr(2, VEC[i][53:46]); wr(3, VEC[i][45:38]);
      cyc(VEC[i][37:6], 1);
      outs($sformatf("R5 R6 R7 R8 R10 vec %0d", i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end
    @(negedge clk); rst_n = 0; bus_strobe = 0;
    @(negedge clk); rst_n = 1;
    rd("R4 reset restores flag", 0, 8'h40);
    cyc(32'hAAAA_AAAA, 1);
    outs("R3 boot after reset", 4'b1110, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule